// File: doc/BRIEF.md
# In-Order Writeback Order Control Buffer

This block decides which execution unit may drive the shared writeback bus, and it does so strictly in the order the instructions were issued. Every time the issue stage advances an instruction into any unit, the block stores that unit's one-hot identifier at the tail of a small FIFO. The entry at the head names the one unit that holds the writeback grant. When that unit says its result is ready, writeback advances and the head entry retires.

Each unit has its own writeback output register. On an advance, the granted unit's register loads that unit's result and every other unit's register loads zero. The primary result word is the bitwise OR of all these registers. A second word lane carries the low half of a double-precision result from the floating-point unit. An empty flag lets control logic hold a special-register move until all outstanding work has retired. A full flag stalls issue. A flush input drops all pending entries.

Top module: `wb_order_buffer`

## Requirements
- R1: While reset is asserted (rstN low), bufEmpty is 1, and bufFull, grant, wbAdvance, wbWord1 and wbWord2 are all 0.
- R2: grant is the one-hot identifier of the oldest entry that has not retired, taken from the issueUnit value pushed with it, and it is 0 when the buffer is empty. Units are therefore granted strictly in issue order. Bit i of issueUnit, grant and unitReady stands for unit i.
- R3: wbAdvance is 1 in a cycle exactly when grant is nonzero and the unitReady bit of the granted unit is 1. A ready unit that is not at the head does not advance writeback.
- R4: In the cycle after an advance, wbWord1 equals the granted unit's unitResult slice (unit i occupies bits i*DATA_W upward). The units that were not granted contribute zero.
- R5: In a cycle without an advance, wbWord1 and wbWord2 hold their values on the following cycle.
- R6: In the cycle after an advance, wbWord2 equals dpLoWord if the granted unit was unit DP_UNIT (3 by default), and 0 otherwise.
- R7: The head entry retires on every advance, and bufEmpty is 1 exactly when no entry is pending.
- R8: bufFull is 1 when DEPTH entries are pending. A push while full and without an advance in the same cycle is dropped. A push and an advance in the same cycle while full are both accepted.
- R9: In a cycle with flush high, grant and wbAdvance are 0. All entries are dropped on the next edge, including a push made in that same cycle. The writeback words are left unchanged.
- R10: A push and an advance in the same cycle on a buffer that is not empty leave the number of pending entries unchanged and keep the issue order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Drop all pending entries |
| issuePush | input | 1 | Issue-advance event; pushes one entry |
| issueUnit | input | NUM_UNITS | One-hot identifier of the unit being issued to |
| unitReady | input | NUM_UNITS | Per-unit result-ready flags |
| unitResult | input | NUM_UNITS*DATA_W | Per-unit primary result words, packed by unit index |
| dpLoWord | input | DATA_W | Low word of the double-precision unit's result |
| grant | output | NUM_UNITS | One-hot writeback grant |
| wbAdvance | output | 1 | Writeback advances this cycle |
| wbWord1 | output | DATA_W | Primary writeback word (OR of unit registers) |
| wbWord2 | output | DATA_W | Secondary writeback word (double-precision low half) |
| bufEmpty | output | 1 | No pending entries |
| bufFull | output | 1 | DEPTH entries pending |

## Verification
grant and wbAdvance are combinational from the stored head and the ready inputs, so they are due in the same cycle as the stimulus. bufEmpty and bufFull follow a push, an advance or a flush after one clock edge. wbWord1 and wbWord2 are due one edge after the advance that loads them. The bench drives its inputs just after a rising edge and compares every output at the falling edge. It keeps a reference queue of issued units and applies that cycle's retire and push to the queue only after the comparison, so each expected value lines up with the edge that produces it.

// File: rtl/obc_pkg.sv
package obc_pkg;

  // Strobes from the order control to the datapath
  typedef struct packed {
    logic push;     // write issueUnit at the tail slot this cycle
    logic grantEn;  // head entry is valid and not being flushed
  } obcStrobes_t;

endpackage

// File: rtl/obc_ctrl.sv
module obc_ctrl
  import obc_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flush,
  input  logic             issuePush,
  input  logic             wbAdvance,
  output obcStrobes_t      strobes,
  output logic [PTR_W-1:0] wrPtr,
  output logic [PTR_W-1:0] rdPtr,
  output logic             bufEmpty,
  output logic             bufFull
);

  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

  logic [CNT_W-1:0] count;
  logic             popNow;
  logic             pushNow;

  assign bufEmpty = (count == '0);
  assign bufFull  = (count == CNT_MAX);

  // The datapath raises an advance only while the grant is enabled
  assign popNow  = wbAdvance;
  assign pushNow = issuePush && !flush && (!bufFull || popNow);

  assign strobes.push    = pushNow;
  assign strobes.grantEn = !bufEmpty && !flush;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN || flush) begin
      count <= '0;
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (pushNow) wrPtr <= nextPtr(wrPtr);
      if (popNow)  rdPtr <= nextPtr(rdPtr);
      case ({pushNow, popNow})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_MAX);

  assert_full_drop_R8: assert property (@(posedge clk) disable iff (!rstN)
    (bufFull && issuePush && !wbAdvance && !flush) |=> bufFull);

  assert_flush_clears_R9: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> bufEmpty);

  assert_advance_nonempty_R7: assert property (@(posedge clk) disable iff (!rstN)
    wbAdvance |-> !bufEmpty);

  assert_pushpop_level_R10: assert property (@(posedge clk) disable iff (!rstN)
    (pushNow && popNow) |=> $stable(count));

endmodule

// File: rtl/obc_wb_slot.sv
module obc_wb_slot #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              advance,
  input  logic              granted,
  input  logic [DATA_W-1:0] result,
  output logic [DATA_W-1:0] slotOut
);

  // On an advance the granted slot takes its result and every other slot clears
  always_ff @(posedge clk) begin
    if (!rstN)
      slotOut <= '0;
    else if (advance)
      slotOut <= granted ? result : '0;
  end

endmodule

// File: rtl/obc_datapath.sv
module obc_datapath
  import obc_pkg::*;
#(
  parameter int NUM_UNITS = 4,
  parameter int DEPTH     = 4,
  parameter int DATA_W    = 32,
  parameter int DP_UNIT   = 3,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  obcStrobes_t                 strobes,
  input  logic [PTR_W-1:0]            wrPtr,
  input  logic [PTR_W-1:0]            rdPtr,
  input  logic [NUM_UNITS-1:0]        issueUnit,
  input  logic [NUM_UNITS-1:0]        unitReady,
  input  logic [NUM_UNITS*DATA_W-1:0] unitResult,
  input  logic [DATA_W-1:0]           dpLoWord,
  output logic [NUM_UNITS-1:0]        grant,
  output logic                        wbAdvance,
  output logic [DATA_W-1:0]           wbWord1,
  output logic [DATA_W-1:0]           wbWord2
);

  logic [NUM_UNITS-1:0] idMem [DEPTH];
  logic [DATA_W-1:0]    slotOut [NUM_UNITS];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) idMem[i] <= '0;
    end else if (strobes.push) begin
      idMem[wrPtr] <= issueUnit;
    end
  end

  assign grant     = strobes.grantEn ? idMem[rdPtr] : '0;
  assign wbAdvance = |(grant & unitReady);

  for (genvar g = 0; g < NUM_UNITS; g++) begin : gUnitSlot
    obc_wb_slot #(.DATA_W(DATA_W)) i_slot (
      .clk     (clk),
      .rstN    (rstN),
      .advance (wbAdvance),
      .granted (grant[g]),
      .result  (unitResult[g*DATA_W +: DATA_W]),
      .slotOut (slotOut[g])
    );
  end

  obc_wb_slot #(.DATA_W(DATA_W)) i_loSlot (
    .clk     (clk),
    .rstN    (rstN),
    .advance (wbAdvance),
    .granted (grant[DP_UNIT]),
    .result  (dpLoWord),
    .slotOut (wbWord2)
  );

  always_comb begin
    wbWord1 = '0;
    for (int u = 0; u < NUM_UNITS; u++) wbWord1 = wbWord1 | slotOut[u];
  end

  assert_grant_onehot_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grant));

  assert_words_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    !wbAdvance |=> ($stable(wbWord1) && $stable(wbWord2)));

  assert_lo_lane_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    (wbAdvance && !grant[DP_UNIT]) |=> (wbWord2 == '0));

endmodule

// File: rtl/wb_order_buffer.sv
module wb_order_buffer
  import obc_pkg::*;
#(
  parameter int NUM_UNITS = 4,
  parameter int DEPTH     = 4,
  parameter int DATA_W    = 32,
  parameter int DP_UNIT   = 3
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        flush,
  input  logic                        issuePush,
  input  logic [NUM_UNITS-1:0]        issueUnit,
  input  logic [NUM_UNITS-1:0]        unitReady,
  input  logic [NUM_UNITS*DATA_W-1:0] unitResult,
  input  logic [DATA_W-1:0]           dpLoWord,
  output logic [NUM_UNITS-1:0]        grant,
  output logic                        wbAdvance,
  output logic [DATA_W-1:0]           wbWord1,
  output logic [DATA_W-1:0]           wbWord2,
  output logic                        bufEmpty,
  output logic                        bufFull
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  obcStrobes_t      strobes;
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;

  obc_ctrl #(.DEPTH(DEPTH)) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .flush     (flush),
    .issuePush (issuePush),
    .wbAdvance (wbAdvance),
    .strobes   (strobes),
    .wrPtr     (wrPtr),
    .rdPtr     (rdPtr),
    .bufEmpty  (bufEmpty),
    .bufFull   (bufFull)
  );

  obc_datapath #(
    .NUM_UNITS (NUM_UNITS),
    .DEPTH     (DEPTH),
    .DATA_W    (DATA_W),
    .DP_UNIT   (DP_UNIT)
  ) i_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .wrPtr      (wrPtr),
    .rdPtr      (rdPtr),
    .issueUnit  (issueUnit),
    .unitReady  (unitReady),
    .unitResult (unitResult),
    .dpLoWord   (dpLoWord),
    .grant      (grant),
    .wbAdvance  (wbAdvance),
    .wbWord1    (wbWord1),
    .wbWord2    (wbWord2)
  );

endmodule

// File: tb/test_wb_order_buffer.sv
`timescale 1ns/1ps
module test_wb_order_buffer;

  localparam int NU = 4;
  localparam int DP = 4;
  localparam int DW = 32;
  localparam int DPU = 3;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic           flush = 1'b0;
  logic           issuePush = 1'b0;
  logic [NU-1:0]  issueUnit = '0;
  logic [NU-1:0]  unitReady = '0;
  logic [NU*DW-1:0] unitResult = '0;
  logic [DW-1:0]  dpLoWord = '0;
  logic [NU-1:0]  grant;
  logic           wbAdvance;
  logic [DW-1:0]  wbWord1;
  logic [DW-1:0]  wbWord2;
  logic           bufEmpty;
  logic           bufFull;

  int errors = 0;
  int checks = 0;
  int tick = 0;
  bit done = 1'b0;

  int refQ[$];
  logic [DW-1:0] expW1 = '0;
  logic [DW-1:0] expW2 = '0;

  always #4 clk = ~clk;

  wb_order_buffer #(.NUM_UNITS(NU), .DEPTH(DP), .DATA_W(DW), .DP_UNIT(DPU)) i_wb_order_buffer (
    .clk(clk), .rstN(rstN), .flush(flush), .issuePush(issuePush), .issueUnit(issueUnit),
    .unitReady(unitReady), .unitResult(unitResult), .dpLoWord(dpLoWord), .grant(grant),
    .wbAdvance(wbAdvance), .wbWord1(wbWord1), .wbWord2(wbWord2), .bufEmpty(bufEmpty),
    .bufFull(bufFull)
  );

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at %0t: actual=%h expected=%h", req, $time, act, exp);
    end
  endtask

  // Driver: present one cycle of stimulus just after a rising edge
  task automatic step(input bit push, input int unit, input logic [NU-1:0] ready, input bit fl);
    @(posedge clk);
    #1;
    tick++;
    issuePush = push;
    issueUnit = push ? NU'(1 << unit) : '0;
    unitReady = ready;
    flush     = fl;
    for (int u = 0; u < NU; u++)
      unitResult[u*DW +: DW] = {8'(8'hA0 + u), 24'(tick)};
    dpLoWord = {8'h5C, 24'(tick * 7)};
  endtask

  // Monitor / scoreboard: compare at the falling edge, then apply this cycle's effects
  always @(negedge clk) begin
    if (rstN && !done) begin
      automatic logic [NU-1:0] expGrant;
      automatic bit expAdv;
      automatic string tagG;
      automatic string tagA;
      expGrant = (flush || refQ.size() == 0) ? '0 : NU'(1 << refQ[0]);
      expAdv   = (expGrant != '0) && unitReady[refQ[0]];
      tagG = flush ? "R9 grant in flush" : "R2 grant order";
      tagA = flush ? "R9 advance in flush" : "R3 advance";
      check(wbWord1 == expW1, "R4/R5 wbWord1", wbWord1, expW1);
      check(wbWord2 == expW2, "R6 wbWord2", wbWord2, expW2);
      check(bufEmpty == (refQ.size() == 0), "R7 bufEmpty", DW'(bufEmpty), DW'(refQ.size() == 0));
      check(bufFull == (refQ.size() == DP), "R8 bufFull", DW'(bufFull), DW'(refQ.size() == DP));
      check(grant == expGrant, tagG, DW'(grant), DW'(expGrant));
      check(wbAdvance == expAdv, tagA, DW'(wbAdvance), DW'(expAdv));
      if (flush) begin
        refQ.delete();
      end else begin
        if (expAdv) begin
          expW1 = unitResult[refQ[0]*DW +: DW];
          expW2 = (refQ[0] == DPU) ? dpLoWord : '0;
          void'(refQ.pop_front());
        end
        if (issuePush && refQ.size() < DP) begin
          for (int u = 0; u < NU; u++) if (issueUnit[u]) refQ.push_back(u);
        end
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check(bufEmpty == 1'b1, "R1 bufEmpty", DW'(bufEmpty), 1);
    check(bufFull == 1'b0, "R1 bufFull", DW'(bufFull), 0);
    check(grant == '0, "R1 grant", DW'(grant), 0);
    check(wbAdvance == 1'b0, "R1 wbAdvance", DW'(wbAdvance), 0);
    check(wbWord1 == '0, "R1 wbWord1", wbWord1, 0);
    check(wbWord2 == '0, "R1 wbWord2", wbWord2, 0);
    @(posedge clk); #1 rstN = 1'b1;
    step(0, 0, 4'b0000, 0);

    // R2, R3, R4: in-order retire; a ready non-head unit does not advance
    step(1, 0, 4'b0000, 0);
    step(1, 1, 4'b0000, 0);
    step(1, 2, 4'b0000, 0);
    step(0, 0, 4'b0100, 0);
    step(0, 0, 4'b0001, 0);
    step(0, 0, 4'b0110, 0);
    step(0, 0, 4'b0100, 0);
    step(0, 0, 4'b0000, 0);
    step(0, 0, 4'b0000, 0);   // R5: words hold

    // R6: low lane from the double-precision unit, then zero from another unit
    step(1, 3, 4'b0000, 0);
    step(1, 0, 4'b0000, 0);
    step(0, 0, 4'b1000, 0);
    step(0, 0, 4'b0001, 0);
    step(0, 0, 4'b0000, 0);

    // R8: fill, drop a push while full, then push and retire together while full
    step(1, 0, 4'b0000, 0);
    step(1, 1, 4'b0000, 0);
    step(1, 2, 4'b0000, 0);
    step(1, 3, 4'b0000, 0);
    step(1, 1, 4'b0000, 0);
    step(1, 2, 4'b0001, 0);
    for (int k = 0; k < 6; k++) step(0, 0, 4'b1111, 0);

    // R10: streaming push with retire every cycle
    step(1, 0, 4'b1111, 0);
    step(1, 1, 4'b1111, 0);
    step(1, 3, 4'b1111, 0);
    step(1, 2, 4'b1111, 0);
    step(0, 0, 4'b1111, 0);
    step(0, 0, 4'b0000, 0);
    step(1, 2, 4'b0000, 0);
    step(1, 1, 4'b0100, 0);
    step(1, 0, 4'b0010, 0);
    step(0, 0, 4'b1111, 0);
    step(0, 0, 4'b1111, 0);

    // R9: flush with pending work and a concurrent push, then reuse
    step(1, 0, 4'b0000, 0);
    step(1, 1, 4'b0000, 0);
    step(1, 2, 4'b0000, 0);
    step(1, 3, 4'b1111, 1);
    step(0, 0, 4'b1111, 0);
    step(1, 1, 4'b0000, 0);
    step(0, 0, 4'b0010, 0);
    step(0, 0, 4'b0000, 1);
    step(0, 0, 4'b0000, 0);

    @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog (all requirements): actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule